// File: doc/BRIEF.md
# Double-Buffered Serial Converter Register Front End

This block is the digital side of a 16-bit serial-input converter. A host lowers an active-low select and clocks data in, most significant bit first, on rising edges of a serial clock. The bits go into a shift register. A holding register tracks that shift register. A rising edge on a separate load strobe copies the holding register into the output register, whose value drives the converter code port.

The serial output returns the bit that entered the shift register sixteen shifts earlier. Several devices can therefore share one bus in a daisy chain. An output-enable flag models the three-state driver of that pin. A level-sensitive, active-low clear input forces every register to half scale or to zero. A select pin picks the value, and it is read live.

All external pins are asynchronous to the system clock. They pass through two-flop synchronizers, and edges are detected in the system clock domain. The system clock must run at least four times faster than the serial clock. After a pin edge, the code port updates within four system clocks.

Top module: `serdac_frontend`

## Requirements
- R1: While the synchronous `rst` input is high, the shift, holding and output registers clear to 0x0000. During that time `code_o` reads 0x0000 and `sdo_oe_o` is low.
- R2: While `cs_n_pin` is low, each rising edge of `sck_pin` shifts `sdi_pin` into bit 0, and the earlier bits move one place toward bit 15. A word is therefore received most significant bit first.
- R3: While `cs_n_pin` is high, edges on `sck_pin` do not change the shift register. In the same state `sdo_oe_o` is low and `sdo_o` is 0.
- R4: While `cs_n_pin` is low, `sdo_o` shows bit 15 of the shift register. During a 16-bit transfer, the port therefore emits the previous register contents, most significant bit first.
- R5: A rising edge on `ld_pin` copies the holding register into the output register. A second load with no new shifting leaves `code_o` unchanged.
- R6: While `clr_n_pin` is low, the shift, holding and output registers are forced to 0x8000 when `clr_sel_pin` is high, or to 0x0000 when it is low. The forced value is what a later transfer shifts out.
- R7: A change of `clr_sel_pin` while `clr_n_pin` stays low changes the forced value on `code_o` within four system clocks.
- R8: A rising edge of `cs_n_pin` while `sck_pin` is low shifts in one extra bit from `sdi_pin`. A rising edge while `sck_pin` is high shifts nothing.
- R9: Raising `cs_n_pin` (with `sck_pin` high) between two 8-bit halves keeps the first half, so the two halves form one word.
- R10: With `cs_n_pin` held low across several words, a load captures the last 16 bits shifted before the strobe.
- R11: `code_o` changes only on a load edge or a forced clear. Shifting alone never alters it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high block reset |
| cs_n_pin | input | 1 | Serial select, active low, asynchronous |
| sck_pin | input | 1 | Serial clock, asynchronous |
| sdi_pin | input | 1 | Serial data in |
| ld_pin | input | 1 | Load strobe, rising edge active |
| clr_n_pin | input | 1 | Level clear, active low |
| clr_sel_pin | input | 1 | Clear value select: 1 = 0x8000, 0 = 0x0000 |
| code_o | output | 16 | Output register (converter code) |
| sdo_o | output | 1 | Serial data out (daisy chain) |
| sdo_oe_o | output | 1 | Enable for the serial output driver |

## Verification
A corrupted shift register shows up on `sdo_o` during the next 16-bit transfer. Each bit of the old word appears, most significant first, one serial clock per bit, so a single wrong bit shows within one word time. A wrong holding or output register shows on `code_o` within four system clocks of the next load strobe or clear. An extra or missing shift, for example from the select-release corner case, shifts every following bit by one position. It is therefore caught both in the loaded code and in the word shifted out next.

// File: rtl/serdac_pkg.sv
package serdac_pkg;
  // positions of the external pins in the synchronizer vector
  localparam int PIN_CSN    = 0;
  localparam int PIN_SCK    = 1;
  localparam int PIN_SDI    = 2;
  localparam int PIN_LD     = 3;
  localparam int PIN_CLRN   = 4;
  localparam int PIN_CLRSEL = 5;
  localparam int PIN_COUNT  = 6;

  // positions of the edge-detected signals
  localparam int EDG_CSN   = 0;
  localparam int EDG_SCK   = 1;
  localparam int EDG_LD    = 2;
  localparam int EDG_COUNT = 3;

  typedef struct packed {
    logic shift_en;
    logic din;
    logic force_en;
  } sr_ctrl_t;
endpackage

// File: rtl/serdac_pin_sync.sv
module serdac_pin_sync #(
  parameter int              N      = 6,
  parameter int              STAGES = 2,
  parameter logic [N-1:0]    IDLE   = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o
);
  // STAGES must be 2 or more
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{IDLE[i]}};
      else     chain <= {chain[STAGES-2:0], pin_i[i]};
    end
    assign lvl_o[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/serdac_edge.sv
module serdac_edge #(
  parameter int           N    = 3,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;
  always_ff @(posedge clk) begin
    if (rst) prev_q <= IDLE;
    else     prev_q <= lvl_i;
  end
  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/serdac_shift.sv
module serdac_shift
  import serdac_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  sr_ctrl_t     ctrl_i,
  input  logic [W-1:0] force_val_i,
  output logic [W-1:0] word_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)                  sr_q <= '0;
    else if (ctrl_i.force_en) sr_q <= force_val_i;
    else if (ctrl_i.shift_en) sr_q <= {sr_q[W-2:0], ctrl_i.din};
  end
  assign word_o = sr_q;

  a_r2_msb_first_shift: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i.shift_en && !ctrl_i.force_en) |=>
      (word_o[W-1:1] == $past(word_o[W-2:0]) && word_o[0] == $past(ctrl_i.din)));

  a_r6_shift_forced: assert property (@(posedge clk) disable iff (rst)
    ctrl_i.force_en |=> word_o == $past(force_val_i));
endmodule

// File: rtl/serdac_holdreg.sv
module serdac_holdreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  input  logic         force_i,
  input  logic [W-1:0] force_val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q;

  always_ff @(posedge clk) begin
    if (rst)          q_q <= '0;
    else if (force_i) q_q <= force_val_i;
    else if (load_i)  q_q <= d_i;
  end
  assign q_o = q_q;

  a_r5_load_copies: assert property (@(posedge clk) disable iff (rst)
    (load_i && !force_i) |=> q_o == $past(d_i));

  a_r11_hold_without_load: assert property (@(posedge clk) disable iff (rst)
    (!load_i && !force_i) |=> $stable(q_o));

  a_r6_hold_forced: assert property (@(posedge clk) disable iff (rst)
    force_i |=> q_o == $past(force_val_i));
endmodule

// File: rtl/serdac_frontend.sv
module serdac_frontend
  import serdac_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n_pin,
  input  logic             sck_pin,
  input  logic             sdi_pin,
  input  logic             ld_pin,
  input  logic             clr_n_pin,
  input  logic             clr_sel_pin,
  output logic [WIDTH-1:0] code_o,
  output logic             sdo_o,
  output logic             sdo_oe_o
);
  localparam logic [WIDTH-1:0]     MID_CODE = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [PIN_COUNT-1:0] PIN_IDLE =
    (PIN_COUNT'(1) << PIN_CSN) | (PIN_COUNT'(1) << PIN_CLRN);
  localparam logic [EDG_COUNT-1:0] EDG_IDLE = EDG_COUNT'(1) << EDG_CSN;

  logic [PIN_COUNT-1:0] pins, lvl;
  logic [EDG_COUNT-1:0] edg_lvl, rise;

  assign pins[PIN_CSN]    = cs_n_pin;
  assign pins[PIN_SCK]    = sck_pin;
  assign pins[PIN_SDI]    = sdi_pin;
  assign pins[PIN_LD]     = ld_pin;
  assign pins[PIN_CLRN]   = clr_n_pin;
  assign pins[PIN_CLRSEL] = clr_sel_pin;

  serdac_pin_sync #(.N(PIN_COUNT), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .pin_i(pins), .lvl_o(lvl));

  assign edg_lvl[EDG_CSN] = lvl[PIN_CSN];
  assign edg_lvl[EDG_SCK] = lvl[PIN_SCK];
  assign edg_lvl[EDG_LD]  = lvl[PIN_LD];

  serdac_edge #(.N(EDG_COUNT), .IDLE(EDG_IDLE)) u_edge (
    .clk(clk), .rst(rst), .lvl_i(edg_lvl), .rise_o(rise));

  logic             cs_hi, clr_act;
  logic [WIDTH-1:0] force_val, sr_word, hold_word, out_word;
  sr_ctrl_t         ctrl;

  assign cs_hi     = lvl[PIN_CSN];
  assign clr_act   = ~lvl[PIN_CLRN];
  assign force_val = lvl[PIN_CLRSEL] ? MID_CODE : '0;

  // normal shift on sck rise while selected; one extra shift when the
  // select is released while the serial clock is low
  assign ctrl.shift_en = (~cs_hi & rise[EDG_SCK]) | (rise[EDG_CSN] & ~lvl[PIN_SCK]);
  assign ctrl.din      = lvl[PIN_SDI];
  assign ctrl.force_en = clr_act;

  serdac_shift #(.W(WIDTH)) u_shift (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .force_val_i(force_val), .word_o(sr_word));

  // holding register tracks the shift register every cycle
  serdac_holdreg #(.W(WIDTH)) u_hold (
    .clk(clk), .rst(rst), .load_i(1'b1), .d_i(sr_word),
    .force_i(clr_act), .force_val_i(force_val), .q_o(hold_word));

  serdac_holdreg #(.W(WIDTH)) u_out (
    .clk(clk), .rst(rst), .load_i(rise[EDG_LD]), .d_i(hold_word),
    .force_i(clr_act), .force_val_i(force_val), .q_o(out_word));

  assign code_o = out_word;

  logic sdo_q, sdo_oe_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_q    <= 1'b0;
      sdo_oe_q <= 1'b0;
    end else begin
      sdo_oe_q <= ~cs_hi;
      sdo_q    <= ~cs_hi & sr_word[WIDTH-1];
    end
  end
  assign sdo_o    = sdo_q;
  assign sdo_oe_o = sdo_oe_q;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (code_o == '0 && !sdo_oe_o));

  a_r3_driver_off: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> (!sdo_oe_o && !sdo_o));

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (cs_hi && !rise[EDG_CSN] && !clr_act) |=> $stable(sr_word));

  a_r8_release_extra_shift: assert property (@(posedge clk) disable iff (rst)
    (rise[EDG_CSN] && !lvl[PIN_SCK] && !clr_act) |=>
      sr_word == {$past(sr_word[WIDTH-2:0]), $past(lvl[PIN_SDI])});

  a_r4_sdo_tracks_msb: assert property (@(posedge clk) disable iff (rst)
    !cs_hi |=> sdo_o == $past(sr_word[WIDTH-1]));
endmodule

// File: tb/serdac_frontend_tb_top.sv
module serdac_frontend_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n_pin = 1'b1, sck_pin = 1'b1, sdi_pin = 1'b0, ld_pin = 1'b0;
  logic        clr_n_pin = 1'b1, clr_sel_pin = 1'b0;
  logic [15:0] code_o;
  logic        sdo_o, sdo_oe_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] exp_sr = 16'h0000;
  bit done = 0;

  always #5 clk = ~clk;

  serdac_frontend dut_i (
    .clk(clk), .rst(rst), .cs_n_pin(cs_n_pin), .sck_pin(sck_pin), .sdi_pin(sdi_pin),
    .ld_pin(ld_pin), .clr_n_pin(clr_n_pin), .clr_sel_pin(clr_sel_pin),
    .code_o(code_o), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o));

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic cs_lo();
    cs_n_pin = 1'b0;
    wait_clk(8);
  endtask

  task automatic cs_up();
    cs_n_pin = 1'b1;
    wait_clk(8);
  endtask

  // shifts n bits of 'bits' MSB first; returns what sdo showed before each rise
  task automatic xfer(input logic [31:0] bits, input int n, output logic [31:0] seen);
    seen = '0;
    for (int i = n - 1; i >= 0; i--) begin
      sck_pin = 1'b0;
      sdi_pin = bits[i];
      wait_clk(8);
      seen = {seen[30:0], sdo_o};
      sck_pin = 1'b1;
      wait_clk(8);
      exp_sr = {exp_sr[14:0], bits[i]};
    end
  endtask

  task automatic pulse_load();
    ld_pin = 1'b1;
    wait_clk(8);
    ld_pin = 1'b0;
    wait_clk(8);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin : stim
    logic [31:0] seen;
    logic [15:0] old, w;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(2);
    // R1 reset state
    chk("R1 code after reset", code_o, 16'h0000);
    chk("R1 sdo_oe after reset", sdo_oe_o, 1'b0);

    // R2/R4/R5 single word, then R11 shifting alone does not move code
    cs_lo();
    chk("R4 sdo_oe while selected", sdo_oe_o, 1'b1);
    old = exp_sr;
    xfer(32'h1234, 16, seen);
    cs_up();
    chk("R4 first word out", seen[15:0], old);
    chk("R11 code before load", code_o, 16'h0000);
    pulse_load();
    chk("R2 R5 loaded word", code_o, 16'h1234);

    cs_lo();
    old = exp_sr;
    xfer(32'hBEEF, 16, seen);
    cs_up();
    chk("R4 daisy previous word", seen[15:0], old);
    chk("R11 code unchanged by shifting", code_o, 16'h1234);
    pulse_load();
    chk("R5 second word", code_o, 16'hBEEF);
    pulse_load();
    chk("R5 repeated load no change", code_o, 16'hBEEF);

    // R3 clock toggling while deselected
    for (int k = 0; k < 5; k++) begin
      sdi_pin = k[0];
      sck_pin = 1'b0;
      wait_clk(8);
      sck_pin = 1'b1;
      wait_clk(8);
    end
    chk("R3 sdo_oe low when deselected", sdo_oe_o, 1'b0);
    chk("R3 sdo low when deselected", sdo_o, 1'b0);
    cs_lo();
    old = exp_sr;
    xfer(32'h0F0F, 16, seen);
    cs_up();
    chk("R3 register held while deselected", seen[15:0], 32'hBEEF);
    pulse_load();
    chk("R3 word after idle clocks", code_o, 16'h0F0F);

    // R9 byte mode
    cs_lo();
    xfer(32'hA5, 8, seen);
    cs_up();
    for (int k = 0; k < 3; k++) begin
      sck_pin = 1'b0;
      wait_clk(8);
      sck_pin = 1'b1;
      wait_clk(8);
    end
    cs_lo();
    xfer(32'h3C, 8, seen);
    cs_up();
    pulse_load();
    chk("R9 byte mode word", code_o, 16'hA53C);

    // R10 continuous mode sweep with loads while selected
    cs_lo();
    xfer(32'hFF, 8, seen);
    for (int k = 0; k < 16; k++) begin
      w = (16'h0001 << k) ^ 16'(k * 16'h1111);
      old = exp_sr;
      xfer({16'h0, w}, 16, seen);
      if (k > 0) chk("R10 R4 continuous sdo", seen[15:0], old);
      pulse_load();
      chk("R10 continuous load", code_o, w);
    end
    cs_up();

    // R8 release with sck low -> one extra shift
    cs_lo();
    xfer(32'h1357, 16, seen);
    sck_pin = 1'b0;
    sdi_pin = 1'b1;
    wait_clk(8);
    cs_n_pin = 1'b1;
    wait_clk(8);
    exp_sr = {exp_sr[14:0], 1'b1};
    sck_pin = 1'b1;
    wait_clk(8);
    pulse_load();
    chk("R8 extra shift on release", code_o, 16'h26AF);
    cs_lo();
    xfer(32'h4444, 16, seen);
    cs_up();
    chk("R8 extra-shifted word out", seen[15:0], 32'h26AF);
    pulse_load();
    chk("R8 no shift on release with sck high", code_o, 16'h4444);

    // R6/R7 level clear with live select
    clr_sel_pin = 1'b1;
    clr_n_pin = 1'b0;
    wait_clk(6);
    chk("R6 clear to mid-scale", code_o, 16'h8000);
    clr_sel_pin = 1'b0;
    wait_clk(6);
    chk("R7 select low during clear", code_o, 16'h0000);
    clr_sel_pin = 1'b1;
    wait_clk(6);
    chk("R7 select high again", code_o, 16'h8000);
    clr_n_pin = 1'b1;
    wait_clk(6);
    exp_sr = 16'h8000;
    chk("R6 code held after release", code_o, 16'h8000);
    pulse_load();
    chk("R6 holding register forced", code_o, 16'h8000);
    cs_lo();
    xfer(32'h7777, 16, seen);
    cs_up();
    chk("R6 forced value shifted out", seen[15:0], 32'h8000);
    pulse_load();
    chk("R5 word after clear", code_o, 16'h7777);
    clr_sel_pin = 1'b0;
    clr_n_pin = 1'b0;
    wait_clk(6);
    chk("R6 clear to zero", code_o, 16'h0000);
    clr_n_pin = 1'b1;
    wait_clk(6);
    pulse_load();
    chk("R6 holding register zero", code_o, 16'h0000);

    done = 1;
    report();
  end
endmodule